// File: doc/BRIEF.md
# Panel Power-Save Controller with Shared GPIO Pin

This block sits in an LCD display controller and decides when the chip is in power save. A CPU writes a byte-wide mode register and two single-bit GPIO registers through a simple write/read port. Power save can be requested in two ways. One is a two-bit software field. The other is an active-high hardware request on pin GPIO0, which is enabled by a mode bit and which otherwise works as an ordinary general-purpose I/O.

A four-state sequencer takes the panel down and brings it back up in a fixed order, with each wait measured in frame ticks. On the way down, panel power is removed first and the interface lines go low after the wait. On the way up, the interface lines come back first and panel power returns after the wait. An override bit skips the power-down wait: as soon as power save is requested, panel power is dropped and every interface line is forced low.

Top module: `pwr_save_ctrl`

## Requirements
- R1: The mode register at MODE_ADDR stores the override bit at bit 3, the hardware-request enable at bit 2 and the software field at bits 1:0. It reads back with bits 7:4 at zero. The GPIO config register at GCFG_ADDR keeps only bit 0. All register bits are 0 after reset.
- R2: Software field 00 requests power save. Field 11 is normal operation. The reserved values 01 and 10 also act as normal operation. `ps_active_o` shows the combined request one cycle after the register write edge.
- R3: With the hardware enable at 1, GPIO0 is never driven, whatever the config and data bits hold. A high level on GPIO0, once it has passed the two-flop synchroniser, requests power save. The request drops again when the pin returns low.
- R4: With the hardware enable at 0 and config bit 0 at 0, GPIO0 is an undriven input. Bit 0 of the data register at GDAT_ADDR reads the pin level, delayed by two clock edges.
- R5: With the hardware enable at 0 and config bit 0 at 1, GPIO0 is driven with data bit 0. Reading the data register returns the stored bit, not the pin level.
- R6: Power-down without override: one edge after the request, panel power is off while the interface lines still pass `panel_sig_i`. After exactly WAIT_TICKS frame ticks the lines go low and `ps_done_o` rises.
- R7: Power-up from OFF: one edge after the request clears, the interface lines pass again while power stays off. Panel power returns after exactly WAIT_TICKS frame ticks.
- R8: With the override bit at 1 and power save requested, panel power and all interface lines are low in the same cycle the request appears. The sequencer is in OFF on the next edge.
- R9: While `rst_ni` is low, `gpio0_oe_o` is 0, panel power and the interface lines are off, and the sequencer rests in OFF. After reset the chip stays in power save until software writes field 11.
- R10: `ps_done_o` is high exactly when the sequencer is in OFF. Whenever it is high, panel power and the interface lines are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address for write and read |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data for reg_addr_i |
| frame_tick_i | input | 1 | One-cycle pulse per frame, paces the waits |
| gpio0_i | input | 1 | GPIO0 pin level |
| gpio0_o | output | 1 | GPIO0 output value |
| gpio0_oe_o | output | 1 | GPIO0 output enable |
| panel_sig_i | input | PANEL_W | Panel interface signals from the display pipeline |
| panel_sig_o | output | PANEL_W | Panel interface signals, gated low when off |
| panel_pwr_o | output | 1 | Panel power enable |
| ps_active_o | output | 1 | Power save currently requested |
| ps_done_o | output | 1 | Power save fully entered |

## Verification
The bench counts ticks on both sequencer edges. A counter that is off by one would change power or the interface lines one tick early or late, and a reversed order would cut the interface lines before power. It holds the GPIO pin high during reset and while the hardware enable is set with config 1. A design that let the control bits leak through would drive the pin there. It samples the synchronised request and readback one edge early to catch a missing sync stage. It checks the override in the very cycle of the write, and a design that still waited for the sequencer would leave power on for at least one cycle.

// File: rtl/pwr_save_pkg.sv
package pwr_save_pkg;
  typedef enum logic [1:0] {
    SEQ_ON  = 2'd0,
    SEQ_DN  = 2'd1,
    SEQ_OFF = 2'd2,
    SEQ_UP  = 2'd3
  } seq_state_e;

  localparam logic [1:0] SW_SAVE   = 2'b00;
  localparam logic [1:0] SW_NORMAL = 2'b11;

  typedef struct packed {
    logic       ovr;
    logic       hw_en;
    logic [1:0] sw;
  } mode_t;
endpackage

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwr_save_pkg::*;
#(
  parameter int unsigned         ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]   MODE_ADDR = 4'h3,
  parameter logic [ADDR_W-1:0]   GCFG_ADDR = 4'h8,
  parameter logic [ADDR_W-1:0]   GDAT_ADDR = 4'h9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              pin_sync_i,
  output mode_t             mode_o,
  output logic              gcfg_o,
  output logic              gdat_o,
  output logic [7:0]        rdata_o
);
  mode_t mode_q;
  logic  gcfg_q, gdat_q;
  logic  unused_wdata;

  assign unused_wdata = ^wdata_i[7:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      gcfg_q <= 1'b0;
      gdat_q <= 1'b0;
    end else if (we_i) begin
      if (addr_i == MODE_ADDR) mode_q <= mode_t'(wdata_i[3:0]);
      if (addr_i == GCFG_ADDR) gcfg_q <= wdata_i[0];
      if (addr_i == GDAT_ADDR) gdat_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == MODE_ADDR)      rdata_o = {4'h0, mode_q};
    else if (addr_i == GCFG_ADDR) rdata_o = {7'h00, gcfg_q};
    else if (addr_i == GDAT_ADDR) rdata_o = {7'h00, (gcfg_q && !mode_q.hw_en) ? gdat_q : pin_sync_i};
  end

  assign mode_o = mode_q;
  assign gcfg_o = gcfg_q;
  assign gdat_o = gdat_q;

  AST_MODE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == MODE_ADDR) |=> (mode_q == mode_t'($past(wdata_i[3:0])))); // R1
endmodule

// File: rtl/pwr_gpio.sv
module pwr_gpio (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic hw_en_i,
  input  logic cfg_i,
  input  logic dat_i,
  output logic pin_sync_o,
  output logic oe_o,
  output logic out_o
);
  logic sync1_q, sync2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
    end
  end

  // reset gates the driver directly so control bits cannot matter in reset
  assign oe_o       = rst_ni & ~hw_en_i & cfg_i;
  assign out_o      = oe_o & dat_i;
  assign pin_sync_o = sync2_q;

  AST_HW_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_en_i |-> !oe_o); // R3
  AST_SYNC_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync2_q) |-> $past(sync1_q)); // R4
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_save_pkg::*;
#(
  parameter int unsigned WAIT_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ps_req_i,
  input  logic ovr_i,
  output logic pwr_o,
  output logic if_o,
  output logic done_o
);
  localparam int unsigned     CNT_W    = (WAIT_TICKS > 1) ? $clog2(WAIT_TICKS + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_TICKS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             force_off, wait_done, in_wait;

  assign force_off = ovr_i & ps_req_i;
  assign in_wait   = (state_q == SEQ_DN) || (state_q == SEQ_UP);
  assign wait_done = in_wait && tick_i && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_ON:  if (ps_req_i) state_d = force_off ? SEQ_OFF : SEQ_DN;
      SEQ_DN: begin
        if (force_off)      state_d = SEQ_OFF;
        else if (!ps_req_i) state_d = SEQ_UP;
        else if (wait_done) state_d = SEQ_OFF;
      end
      SEQ_OFF: if (!ps_req_i) state_d = SEQ_UP;
      SEQ_UP: begin
        if (ps_req_i)       state_d = force_off ? SEQ_OFF : SEQ_DN;
        else if (wait_done) state_d = SEQ_ON;
      end
      default: state_d = SEQ_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)    cnt_q <= '0;
      else if (in_wait && tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pwr_o  = (state_q == SEQ_ON) & ~force_off;
  assign if_o   = (state_q != SEQ_OFF) & ~force_off;
  assign done_o = (state_q == SEQ_OFF);

  AST_DN_PWR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_ON && ps_req_i && !ovr_i) |=> (state_q == SEQ_DN && !pwr_o)); // R6
  AST_UP_IF_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_OFF && !ps_req_i) |=> (state_q == SEQ_UP && !pwr_o)); // R7
  AST_OVR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_req_i && ovr_i) |=> (state_q == SEQ_OFF)); // R8
  AST_DONE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!pwr_o && !if_o)); // R10
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST); // R6
endmodule

// File: rtl/pwr_save_ctrl.sv
module pwr_save_ctrl
  import pwr_save_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 4'h3,
  parameter logic [ADDR_W-1:0] GCFG_ADDR  = 4'h8,
  parameter logic [ADDR_W-1:0] GDAT_ADDR  = 4'h9,
  parameter int unsigned       PANEL_W    = 8,
  parameter int unsigned       WAIT_TICKS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic               frame_tick_i,
  input  logic               gpio0_i,
  output logic               gpio0_o,
  output logic               gpio0_oe_o,
  input  logic [PANEL_W-1:0] panel_sig_i,
  output logic [PANEL_W-1:0] panel_sig_o,
  output logic               panel_pwr_o,
  output logic               ps_active_o,
  output logic               ps_done_o
);
  mode_t mode;
  logic  gcfg, gdat, pin_sync, ps_req, if_on;

  pwr_regs #(
    .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .GCFG_ADDR(GCFG_ADDR), .GDAT_ADDR(GDAT_ADDR)
  ) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .pin_sync_i(pin_sync),
    .mode_o(mode), .gcfg_o(gcfg), .gdat_o(gdat), .rdata_o(reg_rdata_o)
  );

  pwr_gpio i_gpio (
    .clk_i, .rst_ni,
    .pin_i(gpio0_i), .hw_en_i(mode.hw_en), .cfg_i(gcfg), .dat_i(gdat),
    .pin_sync_o(pin_sync), .oe_o(gpio0_oe_o), .out_o(gpio0_o)
  );

  // reserved field codes fall through to normal operation
  assign ps_req = (mode.sw == SW_SAVE) | (mode.hw_en & pin_sync);

  pwr_seq #(.WAIT_TICKS(WAIT_TICKS)) i_seq (
    .clk_i, .rst_ni,
    .tick_i(frame_tick_i), .ps_req_i(ps_req), .ovr_i(mode.ovr),
    .pwr_o(panel_pwr_o), .if_o(if_on), .done_o(ps_done_o)
  );

  assign panel_sig_o = if_on ? panel_sig_i : '0;
  assign ps_active_o = ps_req;

  AST_SIG_DARK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_done_o |-> (panel_sig_o == '0)); // R10
  AST_PWR_NEEDS_IF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_pwr_o |-> (panel_sig_o == panel_sig_i)); // R7
endmodule

// File: tb/test_pwr_save_ctrl.sv
`timescale 1ns/1ps
module test_pwr_save_ctrl;
  localparam int unsigned ADDR_W = 4;
  localparam logic [3:0] A_MODE = 4'h3, A_CFG = 4'h8, A_DAT = 4'h9;
  localparam int unsigned PW = 8;
  localparam int unsigned WT = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic we = 1'b0, tick = 1'b0, pin = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic gp_o, gp_oe, pwr, ps_act, ps_done;
  logic [PW-1:0] sig_i = 8'hA5, sig_o;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_save_ctrl #(.ADDR_W(ADDR_W), .MODE_ADDR(A_MODE), .GCFG_ADDR(A_CFG), .GDAT_ADDR(A_DAT),
                  .PANEL_W(PW), .WAIT_TICKS(WT)) i_pwr_save_ctrl (
    .clk_i(clk), .rst_ni, .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .frame_tick_i(tick), .gpio0_i(pin), .gpio0_o(gp_o),
    .gpio0_oe_o(gp_oe), .panel_sig_i(sig_i), .panel_sig_o(sig_o), .panel_pwr_o(pwr),
    .ps_active_o(ps_act), .ps_done_o(ps_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic go_off();
    wr(A_MODE, 8'h00);
    ticks(WT + 1);
    check("R10 settle", ps_done, 1'b1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    repeat (2) @(negedge clk);
    pin = 1'b1;
    @(negedge clk);
    check("R9 oe in reset", gp_oe, 1'b0);
    check("R9 pwr in reset", pwr, 1'b0);
    check("R9 sig in reset", sig_o, 8'h00);
    rst_ni = 1'b1;
    pin = 1'b0;
    repeat (3) @(negedge clk);
    rd(A_MODE, d);
    check("R1 mode reset", d, 8'h00);
    rd(A_CFG, d);
    check("R1 cfg reset", d, 8'h00);
    check("R9 ps after reset", ps_act, 1'b1);
    check("R9 done after reset", ps_done, 1'b1);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(A_MODE, 8'hF6);
    rd(A_MODE, d);
    check("R1 mode readback", d, 8'h06);
    wr(A_CFG, 8'hFF);
    rd(A_CFG, d);
    check("R1 cfg readback", d, 8'h01);
    wr(A_CFG, 8'h00);
    go_off();
  endtask

  task automatic t_seq();
    wr(A_MODE, 8'h03);
    check("R7 not yet up", ps_done, 1'b1);
    @(negedge clk);
    check("R7 if first", sig_o, 8'hA5);
    check("R7 pwr still off", pwr, 1'b0);
    check("R10 done low", ps_done, 1'b0);
    ticks(WT - 1);
    check("R7 pwr early", pwr, 1'b0);
    ticks(1);
    check("R7 pwr on", pwr, 1'b1);
    sig_i = 8'h3C;
    wr(A_MODE, 8'h00);
    check("R6 no force w/o ovr", pwr, 1'b1);
    @(negedge clk);
    check("R6 pwr first", pwr, 1'b0);
    check("R6 if held", sig_o, 8'h3C);
    ticks(WT - 1);
    check("R6 if early", sig_o, 8'h3C);
    check("R10 not done early", ps_done, 1'b0);
    ticks(1);
    check("R6 if low", sig_o, 8'h00);
    check("R10 done", ps_done, 1'b1);
    sig_i = 8'hA5;
  endtask

  task automatic t_sw_modes();
    wr(A_MODE, 8'h01);
    check("R2 code 01", ps_act, 1'b0);
    wr(A_MODE, 8'h02);
    check("R2 code 10", ps_act, 1'b0);
    wr(A_MODE, 8'h03);
    check("R2 code 11", ps_act, 1'b0);
    wr(A_MODE, 8'h00);
    check("R2 code 00", ps_act, 1'b1);
    go_off();
  endtask

  task automatic t_override();
    wr(A_MODE, 8'h03);
    @(negedge clk);
    ticks(WT);
    check("R8 pre on", pwr, 1'b1);
    wr(A_MODE, 8'h08);
    check("R8 pwr forced", pwr, 1'b0);
    check("R8 sig forced", sig_o, 8'h00);
    @(negedge clk);
    check("R8 off next", ps_done, 1'b1);
    wr(A_MODE, 8'h0B);
    @(negedge clk);
    check("R7 up w/ ovr", sig_o, 8'hA5);
    ticks(WT);
    check("R7 pwr w/ ovr", pwr, 1'b1);
    go_off();
  endtask

  task automatic t_gpio();
    logic [7:0] d;
    wr(A_MODE, 8'h03);
    wr(A_CFG, 8'h00);
    check("R4 input oe", gp_oe, 1'b0);
    addr = A_DAT;
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    rd(A_DAT, d);
    check("R4 one stage", d, 8'h00);
    @(negedge clk);
    rd(A_DAT, d);
    check("R4 pin read", d, 8'h01);
    pin = 1'b0;
    repeat (2) @(negedge clk);
    wr(A_CFG, 8'h01);
    wr(A_DAT, 8'h00);
    check("R5 oe", gp_oe, 1'b1);
    check("R5 out 0", gp_o, 1'b0);
    wr(A_DAT, 8'h01);
    check("R5 out 1", gp_o, 1'b1);
    rd(A_DAT, d);
    check("R5 data read", d, 8'h01);
  endtask

  task automatic t_hw();
    logic [7:0] d;
    wr(A_MODE, 8'h07);
    check("R3 oe off", gp_oe, 1'b0);
    check("R3 no req", ps_act, 1'b0);
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    check("R3 sync wait", ps_act, 1'b0);
    @(negedge clk);
    check("R3 hw req", ps_act, 1'b1);
    check("R3 oe still off", gp_oe, 1'b0);
    rd(A_DAT, d);
    check("R3 pin read", d, 8'h01);
    pin = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 req drop", ps_act, 1'b0);
    wr(A_MODE, 8'h03);
    check("R5 oe back", gp_oe, 1'b1);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_seq();
    t_sw_modes();
    t_override();
    t_gpio();
    t_hw();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule